// File: doc/BRIEF.md
# Probe Trigger Comparator

This block watches one probe bus and raises a one-bit match flag when the probe meets a condition that software can change at any time. The condition is set by an operator code, a compare value and a per-bit mask. The block supports several kinds of condition:

- a masked equality or inequality test, where masked bits are don't-care;
- an unsigned magnitude test against the compare value;
- a per-bit edge test that compares the probe with its value on the previous cycle.

The block keeps a one-entry history of the probe for the edge test. It registers its verdict, so the flag appears one clock after the probe value that caused it. It is meant to sit beside each probe of an on-chip analyser, and later logic combines the flags of several probes.

Top module: `probe_trigger_cmp`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `trig_match` is 0. The history register is cleared to all zeros.
- R2: Operator code 0 (equal) matches when every probe bit whose `care_mask` bit is 1 equals the same bit of `cmp_value`. Bits whose mask bit is 0 are don't-care. With an all-zero mask, this code matches on every sample.
- R3: Operator code 1 (not equal) matches when at least one probe bit whose mask bit is 1 differs from `cmp_value`. With an all-zero mask, this code never matches.
- R4: Operator codes 2 (greater), 3 (less), 4 (greater or equal) and 5 (less or equal) compare the whole probe, as an unsigned number, with `cmp_value`. These codes ignore `care_mask`.
- R5: Operator code 6 (edge) takes a 2-bit class for each bit i from `edge_sel[2i+1:2i]`. The classes are 0 rising (previous 0, now 1), 1 falling (previous 1, now 0), 2 either edge (bit changed) and 3 no transition (bit unchanged). The result is the AND over all bits whose `care_mask` bit is 1. With an all-zero mask, this code matches on every sample after the first.
- R6: Operator code 6 never matches on the first probe sample taken after reset, because no previous value exists yet.
- R7: Operator codes 7 to 15 never match.
- R8: `trig_match` after clock edge k reflects the inputs sampled at edge k and the probe sampled at edge k-1. The operator, compare value, mask and edge classes may all change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for history and result registers |
| rst | input | 1 | Synchronous active-high reset |
| probe | input | WIDTH | Monitored signal |
| op_code | input | 4 | Comparison operator selector |
| cmp_value | input | WIDTH | Value compared against the probe |
| care_mask | input | WIDTH | 1 = bit takes part in equality and edge tests |
| edge_sel | input | 2*WIDTH | Edge class for each probe bit |
| trig_match | output | 1 | Registered comparison result |

## Verification
The checker checks the following on every cycle: reset clears the flag, unused codes stay silent, equality and greater-than hits appear one clock later, the first post-reset edge sample is suppressed, and a rising edge on bit 0 is detected. The other operators, the mask interaction and the four edge classes on wider buses are shown only by the bench's scenarios. In those scenarios a reference model tracks the previous probe value and checks random and directed patterns, including magnitude boundaries at equality, zero and all-ones.

// File: rtl/trig_cmp_pkg.sv
package trig_cmp_pkg;
  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_NE   = 4'd1,
    OP_GT   = 4'd2,
    OP_LT   = 4'd3,
    OP_GE   = 4'd4,
    OP_LE   = 4'd5,
    OP_EDGE = 4'd6
  } cmp_op_e;

  typedef enum logic [1:0] {
    EC_RISE = 2'd0,
    EC_FALL = 2'd1,
    EC_ANY  = 2'd2,
    EC_HOLD = 2'd3
  } edge_class_e;
endpackage

// File: rtl/probe_history.sv
module probe_history #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] probe,
  output logic [WIDTH-1:0] prev_probe,
  output logic             prev_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_probe <= '0;
      prev_valid <= 1'b0;
    end else begin
      prev_probe <= probe;
      prev_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/level_compare.sv
module level_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] probe,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic [WIDTH-1:0] care_mask,
  output logic             hit_eq,
  output logic             hit_gt,
  output logic             hit_lt
);
  logic [WIDTH-1:0] diff_bits;

  always_comb begin
    diff_bits = (probe ^ cmp_value) & care_mask;
    hit_eq    = (diff_bits == '0);
    hit_gt    = (probe > cmp_value);
    hit_lt    = (probe < cmp_value);
  end
endmodule

// File: rtl/edge_compare.sv
module edge_compare
  import trig_cmp_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SELW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] probe,
  input  logic [WIDTH-1:0] prev_probe,
  input  logic             prev_valid,
  input  logic [WIDTH-1:0] care_mask,
  input  logic [SELW-1:0]  edge_sel,
  output logic             hit_edge
);
  logic [WIDTH-1:0] bit_ok;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    edge_class_e cls;
    logic        ok;
    always_comb begin
      cls = edge_class_e'(edge_sel[2*i +: 2]);
      unique case (cls)
        EC_RISE: ok = !prev_probe[i] &&  probe[i];
        EC_FALL: ok =  prev_probe[i] && !probe[i];
        EC_ANY:  ok =  prev_probe[i] ^   probe[i];
        default: ok =  prev_probe[i] ==  probe[i];
      endcase
      bit_ok[i] = ok || !care_mask[i];
    end
  end

  assign hit_edge = prev_valid && (&bit_ok);
endmodule

// File: rtl/probe_trigger_cmp.sv
module probe_trigger_cmp
  import trig_cmp_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SELW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] probe,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic [WIDTH-1:0] care_mask,
  input  logic [SELW-1:0]  edge_sel,
  output logic             trig_match
);
  logic [WIDTH-1:0] prev_probe;
  logic             prev_valid;
  logic             hit_eq, hit_gt, hit_lt, hit_edge;
  logic             match_d;

  probe_history #(.WIDTH(WIDTH)) u_hist (
    .clk(clk), .rst(rst), .probe(probe),
    .prev_probe(prev_probe), .prev_valid(prev_valid)
  );

  level_compare #(.WIDTH(WIDTH)) u_level (
    .probe(probe), .cmp_value(cmp_value), .care_mask(care_mask),
    .hit_eq(hit_eq), .hit_gt(hit_gt), .hit_lt(hit_lt)
  );

  edge_compare #(.WIDTH(WIDTH)) u_edge (
    .probe(probe), .prev_probe(prev_probe), .prev_valid(prev_valid),
    .care_mask(care_mask), .edge_sel(edge_sel), .hit_edge(hit_edge)
  );

  always_comb begin
    case (op_code)
      OP_EQ:   match_d = hit_eq;
      OP_NE:   match_d = !hit_eq;
      OP_GT:   match_d = hit_gt;
      OP_LT:   match_d = hit_lt;
      OP_GE:   match_d = !hit_lt;
      OP_LE:   match_d = !hit_gt;
      OP_EDGE: match_d = hit_edge;
      default: match_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trig_match <= 1'b0;
    else     trig_match <= match_d;
  end
endmodule

// File: rtl/probe_trigger_cmp_chk.sv
module probe_trigger_cmp_chk #(
  parameter int WIDTH = 8,
  localparam int SELW = 2 * WIDTH
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] probe,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] cmp_value,
  input logic [WIDTH-1:0] care_mask,
  input logic [SELW-1:0]  edge_sel,
  input logic             trig_match
);
  always @(negedge clk) begin
    if (rst) AST_RESET_QUIET: assert (!trig_match || $time < 1); // R1
  end

  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (op_code > 4'd6) |=> !trig_match); // R7

  AST_EQ_HIT: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd0 && ((probe ^ cmp_value) & care_mask) == '0) |=> trig_match); // R2

  AST_GT_HIT: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd2 && probe > cmp_value) |=> trig_match); // R4

  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd6 && $fell(rst)) |=> !trig_match); // R6

  AST_RISE_BIT0: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd6 && care_mask == WIDTH'(1) && edge_sel[1:0] == 2'd0 &&
     !$fell(rst) && !$past(probe[0]) && probe[0]) |=> trig_match); // R5
endmodule

bind probe_trigger_cmp probe_trigger_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .probe(probe), .op_code(op_code),
  .cmp_value(cmp_value), .care_mask(care_mask), .edge_sel(edge_sel),
  .trig_match(trig_match)
);

// File: tb/tb_probe_trigger_cmp.sv
module tb_probe_trigger_cmp;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   probe = '0;
  logic [3:0]     op_code = '0;
  logic [W-1:0]   cmp_value = '0;
  logic [W-1:0]   care_mask = '0;
  logic [2*W-1:0] edge_sel = '0;
  logic           trig_match;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m_prev = '0;
  logic         m_valid = 1'b0;
  bit           done = 0;

  always #10 clk = ~clk;

  probe_trigger_cmp #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .probe(probe), .op_code(op_code),
    .cmp_value(cmp_value), .care_mask(care_mask), .edge_sel(edge_sel),
    .trig_match(trig_match)
  );

  function automatic logic ref_match(
    input logic [W-1:0] p, input logic [3:0] op, input logic [W-1:0] c,
    input logic [W-1:0] m, input logic [2*W-1:0] es,
    input logic [W-1:0] pv, input logic vld);
    logic r;
    case (op)
      4'd0: r = ((p & m) == (c & m));
      4'd1: r = ((p & m) != (c & m));
      4'd2: r = p > c;
      4'd3: r = p < c;
      4'd4: r = p >= c;
      4'd5: r = p <= c;
      4'd6: begin
        r = vld;
        for (int i = 0; i < W; i++) begin
          if (m[i]) begin
            case (es[2*i +: 2])
              2'd0: r = r & (pv[i] == 1'b0 && p[i] == 1'b1);
              2'd1: r = r & (pv[i] == 1'b1 && p[i] == 1'b0);
              2'd2: r = r & (pv[i] != p[i]);
              default: r = r & (pv[i] == p[i]);
            endcase
          end
        end
      end
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (trig_match !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%0d probe=%h cmp=%h mask=%h got=%b exp=%b",
               req, op_code, probe, cmp_value, care_mask, trig_match, exp);
    end
  endtask

  // drive at negedge, clock in, check at following negedge
  task automatic apply(input logic [W-1:0] p, input logic [3:0] op,
                       input logic [W-1:0] c, input logic [W-1:0] m,
                       input logic [2*W-1:0] es, input string req);
    logic e;
    probe = p; op_code = op; cmp_value = c; care_mask = m; edge_sel = es;
    e = ref_match(p, op, c, m, es, m_prev, m_valid);
    @(posedge clk);
    m_prev = p; m_valid = 1'b1;
    @(negedge clk);
    check(e, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    m_prev = '0; m_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R6: rising on bit0 from the cleared history would match if history were valid
    apply(8'h01, 4'd6, '0, 8'h01, '0, "R6");
    apply(8'h00, 4'd6, '0, 8'h01, 16'h0001, "R5 fall");
    apply(8'h01, 4'd6, '0, 8'h01, 16'h0000, "R5 rise");
    apply(8'h01, 4'd6, '0, 8'h01, 16'h0003, "R5 hold");
    apply(8'h81, 4'd6, '0, 8'h80, 16'h8000, "R5 any");
    apply(8'h5A, 4'd6, '0, 8'h00, '0, "R5 nomask");
    // equality with don't-cares
    apply(8'hA5, 4'd0, 8'hAF, 8'hF0, '0, "R2");
    apply(8'hA5, 4'd0, 8'hAF, 8'hFF, '0, "R2");
    apply(8'h3C, 4'd0, 8'hC3, 8'h00, '0, "R2 allmask");
    apply(8'h3C, 4'd1, 8'hC3, 8'h00, '0, "R3 allmask");
    apply(8'h3C, 4'd1, 8'h3D, 8'h01, '0, "R3");
    // magnitude boundaries, mask ignored
    apply(8'h40, 4'd2, 8'h40, 8'h00, '0, "R4 gt eq");
    apply(8'h40, 4'd4, 8'h40, 8'h00, '0, "R4 ge eq");
    apply(8'h00, 4'd5, 8'h00, 8'hFF, '0, "R4 le zero");
    apply(8'hFF, 4'd3, 8'hFF, 8'h00, '0, "R4 lt max");
    apply(8'hFF, 4'd2, 8'hFE, 8'h00, '0, "R4 gt max");
    // unused codes
    for (int k = 7; k < 16; k++) apply(8'h00, 4'(k), 8'h00, 8'h00, '0, "R7");
    // random mix, operator changing each cycle
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] p, c, m;
      logic [3:0] op;
      p = W'($urandom);
      c = ($urandom_range(0, 3) == 0) ? p : W'($urandom);
      m = W'($urandom);
      op = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'($urandom_range(0, 6));
      if (op == 4'd6 && $urandom_range(0, 1) == 1) begin
        m = W'(1) << $urandom_range(0, W - 1);
        p = m_prev ^ (W'($urandom_range(0, 1)) ? m : '0);
      end
      apply(p, op, c, m, (2*W)'({$urandom, $urandom}), "R8 random");
    end
    // reset again mid-run then first-sample suppression
    do_reset();
    apply(8'hFF, 4'd6, '0, 8'hFF, {W{2'b00}}, "R6 again");
    apply(8'hFF, 4'd6, '0, 8'hFF, {W{2'b11}}, "R5 hold all");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got=timeout exp=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule